// File: doc/BRIEF.md
# Wired Interrupt to Message Write Bridge

This block turns a bank of wired interrupt lines into memory-write messages for a downstream interrupt controller. Each line has a 32-bit configuration word on a simple register bus. The word holds an enable, a mode bit, a group number and a payload. Each group owns a programmable 64-bit "raise" target address and a 64-bit "drop" target address. When a line asserts, the block issues a write of the line's payload to its group's raise address. When a level-mode line in the level group deasserts, the block writes the payload to the drop address instead.

Every line is synchronised and then tracked by its own pending flags, so events are not lost while the output is stalled. A round-robin arbiter chooses one pending line at a time and loads a single request register. That register drives a valid/ready write port. Two designated lines form one shared source: either line, or both together, yields one message stream, and that stream uses the configuration of the lower line of the pair.

Top module: `wire_msg_bridge`

## Requirements
- R1: After reset every configuration and address register reads 0 and `msg_valid_o` is low.
- R2: Configuration register n sits at byte offset 0x100+4n. Group 0 raise address low/high words are at 0x10/0x14 and its drop address at 0x18/0x1C. Group 1 uses 0x50/0x54 and 0x58/0x5C. Each register reads back the last value written.
- R3: In a configuration word, bit 24 is the enable and bit 28 selects edge mode. Bits 31:29 are the group: 0 is the level group, 1 is the edge group, and any other value is inactive. Bits 23:0 are the payload, sent zero-extended as the 32-bit message data.
- R4: A level-mode line in group 0 sends a write to the group's raise address when it rises, and a write to its drop address when it falls.
- R5: A line in edge mode, or any line in group 1, sends only a raise-address write on each rising edge and nothing on falling edges.
- R6: A line whose enable is 0 sends no messages, and writing 0 to a configuration word deconfigures the line.
- R7: If a level line falls before its raise write has been accepted, both writes are dropped. If it rises again before its drop write has been accepted, that drop is cancelled.
- R8: While `msg_valid_o` is high and `msg_ready_i` is low, the address and data stay stable and valid stays high.
- R9: Events pending at the same time are delivered one per handshake, with none lost under back-pressure. They are served round-robin, scanning upward from the line after the last one served.
- R10: Lines 107 and 109 act as one source. Asserting either or both gives exactly one raise write, and deasserting gives one drop write, both carrying line 107's payload.
- R11: A line never holds a pending raise and a pending drop at the same time, and only a pending line is granted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | N_IN | Wired interrupt lines, asynchronous |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | REG_AW | Register byte address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i |
| msg_valid_o | output | 1 | Write request valid |
| msg_ready_i | input | 1 | Write request accepted |
| msg_addr_o | output | 64 | Write target address |
| msg_data_o | output | 32 | Write data (payload) |

## Verification
Four properties are checked on every cycle: the stable-request rule under back-pressure, valid only dropping after a handshake, no line pending raise and drop together, and grants going only to pending lines. Address selection per group and kind, the mode and group decode, the cancel rules, round-robin order, and the merging of the shared pair are shown only by the bench's directed scenarios. Those scenarios compare the exact stream of accepted writes against expected values.

// File: rtl/w2m_pkg.sv
package w2m_pkg;
  localparam int          CFG_BASE = 'h100;
  localparam int          EN_BIT   = 24;
  localparam int          EDGE_BIT = 28;
  localparam int          GRP_LSB  = 29;
  localparam int          PAY_W    = 24;
  localparam int          NUM_GRP  = 2;
  localparam logic [2:0]  GRP_LEVEL = 3'd0;
  // address window base per group, 4 words each: raise lo/hi, drop lo/hi
  localparam int          GRP_BASE0 = 'h10;
  localparam int          GRP_BASE1 = 'h50;

  typedef enum logic {KIND_RAISE = 1'b0, KIND_DROP = 1'b1} msg_kind_e;
endpackage

// File: rtl/irq_track.sv
module irq_track (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic irq_i,
  input  logic active_i,
  input  logic level_i,
  input  logic take_i,
  output logic pend_set_o,
  output logic pend_clr_o
);
  logic s1_q, s2_q, s3_q;
  logic set_q, clr_q, set_d, clr_d;
  logic rise, fall;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= 1'b0; s2_q <= 1'b0; s3_q <= 1'b0;
    end else begin
      s1_q <= irq_i; s2_q <= s1_q; s3_q <= s2_q;
    end
  end

  assign rise = s2_q & ~s3_q;
  assign fall = ~s2_q & s3_q;

  always_comb begin
    set_d = set_q;
    clr_d = clr_q;
    if (take_i) begin
      if (set_q) set_d = 1'b0;
      else       clr_d = 1'b0;
    end
    if (rise) begin
      if (clr_d) clr_d = 1'b0;   // level back high: drop no longer due
      else       set_d = 1'b1;
    end else if (fall && level_i) begin
      if (set_d) set_d = 1'b0;   // short pulse: send neither
      else       clr_d = 1'b1;
    end
    if (!active_i) begin
      set_d = 1'b0;
      clr_d = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      set_q <= 1'b0; clr_q <= 1'b0;
    end else begin
      set_q <= set_d; clr_q <= clr_d;
    end
  end

  assign pend_set_o = set_q;
  assign pend_clr_o = clr_q;
endmodule

// File: rtl/rr_pick.sv
module rr_pick #(
  parameter int N     = 8,
  parameter int IDX_W = $clog2(N)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N-1:0]     req_i,
  input  logic             adv_i,
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o
);
  logic [IDX_W-1:0] ptr_q;

  always_comb begin
    any_o = 1'b0;
    idx_o = '0;
    for (int k = 0; k < N; k++) begin
      int j;
      j = int'(ptr_q) + k;
      if (j >= N) j = j - N;
      if (!any_o && req_i[j]) begin
        any_o = 1'b1;
        idx_o = IDX_W'(j);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    ptr_q <= '0;
    else if (adv_i) ptr_q <= (int'(idx_o) == N - 1) ? '0 : idx_o + 1'b1;
  end
endmodule

// File: rtl/wire_msg_bridge.sv
module wire_msg_bridge
  import w2m_pkg::*;
#(
  parameter int N_IN    = 112,
  parameter int SHARE_A = 107,
  parameter int SHARE_B = 109,
  parameter int REG_AW  = 12,
  localparam int IDX_W  = $clog2(N_IN)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_IN-1:0]   irq_i,
  input  logic              reg_wr_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  output logic              msg_valid_o,
  input  logic              msg_ready_i,
  output logic [63:0]       msg_addr_o,
  output logic [31:0]       msg_data_o
);
  logic [31:0] cfg_q [N_IN];
  logic [31:0] ga_q  [NUM_GRP][4];

  logic [REG_AW-1:0] cfg_off;
  logic              cfg_hit;
  logic [IDX_W-1:0]  cfg_idx;

  assign cfg_off = reg_addr_i - REG_AW'(CFG_BASE);
  assign cfg_hit = (int'(reg_addr_i) >= CFG_BASE) && (cfg_off[1:0] == 2'b00)
                 && (int'(cfg_off[REG_AW-1:2]) < N_IN);
  assign cfg_idx = IDX_W'(cfg_off[REG_AW-1:2]);

  function automatic logic grp_hit(input logic [REG_AW-1:0] a, input int g);
    int base;
    base = (g == 0) ? GRP_BASE0 : GRP_BASE1;
    return (int'(a) >= base) && (int'(a) < base + 16) && (a[1:0] == 2'b00);
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N_IN; i++) cfg_q[i] <= '0;
      for (int g = 0; g < NUM_GRP; g++)
        for (int w = 0; w < 4; w++) ga_q[g][w] <= '0;
    end else if (reg_wr_i) begin
      if (cfg_hit) cfg_q[cfg_idx] <= reg_wdata_i;
      for (int g = 0; g < NUM_GRP; g++)
        if (grp_hit(reg_addr_i, g)) ga_q[g][reg_addr_i[3:2]] <= reg_wdata_i;
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    if (cfg_hit) reg_rdata_o = cfg_q[cfg_idx];
    for (int g = 0; g < NUM_GRP; g++)
      if (grp_hit(reg_addr_i, g)) reg_rdata_o = ga_q[g][reg_addr_i[3:2]];
  end

  // per-line tracking
  logic [N_IN-1:0] pend_set, pend_clr, take;
  logic            any_req, grant, slot_free;
  logic [IDX_W-1:0] pick;

  for (genvar i = 0; i < N_IN; i++) begin : g_line
    logic raw, act, lvl;
    if (i == SHARE_A && SHARE_B < N_IN) begin : g_merge
      assign raw = irq_i[SHARE_A] | irq_i[SHARE_B];
    end else if (i == SHARE_B && SHARE_A < N_IN) begin : g_mute
      assign raw = 1'b0;
    end else begin : g_plain
      assign raw = irq_i[i];
    end
    assign act = cfg_q[i][EN_BIT] && (int'(cfg_q[i][31:GRP_LSB]) < NUM_GRP);
    assign lvl = !cfg_q[i][EDGE_BIT] && (cfg_q[i][31:GRP_LSB] == GRP_LEVEL);
    assign take[i] = grant && (int'(pick) == i);

    irq_track u_trk (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .irq_i      (raw),
      .active_i   (act),
      .level_i    (lvl),
      .take_i     (take[i]),
      .pend_set_o (pend_set[i]),
      .pend_clr_o (pend_clr[i])
    );
  end

  rr_pick #(.N(N_IN), .IDX_W(IDX_W)) u_arb (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (pend_set | pend_clr),
    .adv_i  (grant),
    .any_o  (any_req),
    .idx_o  (pick)
  );

  assign slot_free = !msg_valid_o || msg_ready_i;
  assign grant     = slot_free && any_req;

  msg_kind_e  kind;
  logic       gsel;
  assign kind = pend_set[pick] ? KIND_RAISE : KIND_DROP;
  assign gsel = cfg_q[pick][GRP_LSB];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      msg_valid_o <= 1'b0;
      msg_addr_o  <= '0;
      msg_data_o  <= '0;
    end else if (grant) begin
      msg_valid_o <= 1'b1;
      msg_addr_o  <= (kind == KIND_RAISE) ? {ga_q[gsel][1], ga_q[gsel][0]}
                                          : {ga_q[gsel][3], ga_q[gsel][2]};
      msg_data_o  <= {{(32-PAY_W){1'b0}}, cfg_q[pick][PAY_W-1:0]};
    end else if (msg_ready_i) begin
      msg_valid_o <= 1'b0;
    end
  end
endmodule

// File: rtl/w2m_chk.sv
module w2m_chk #(
  parameter int N_IN = 112
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            msg_valid_o,
  input logic            msg_ready_i,
  input logic [63:0]     msg_addr_o,
  input logic [31:0]     msg_data_o,
  input logic [N_IN-1:0] pend_set,
  input logic [N_IN-1:0] pend_clr,
  input logic [N_IN-1:0] take
);
  // R8
  hold_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_valid_o && !msg_ready_i |=> msg_valid_o && $stable(msg_addr_o) && $stable(msg_data_o));

  // R8
  drop_after_hs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(msg_valid_o) |-> $past(msg_ready_i));

  // R11
  no_dual_pend_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_set & pend_clr) == '0);

  // R11
  grant_pending_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(take) && ((take & ~(pend_set | pend_clr)) == '0));
endmodule

bind wire_msg_bridge w2m_chk #(.N_IN(N_IN)) u_chk (.*);

// File: tb/sim_wire_msg_bridge.sv
module sim_wire_msg_bridge;
  localparam int CLK_PERIOD = 10;
  localparam int N_IN = 112;
  localparam logic [31:0] EN = 32'h0100_0000;
  localparam logic [31:0] ED = 32'h1000_0000;
  localparam logic [31:0] G1 = 32'h2000_0000;
  localparam logic [63:0] A0S = 64'h0000_000A_1000_0000;
  localparam logic [63:0] A0C = 64'h0000_000A_2000_0000;
  localparam logic [63:0] A1S = 64'h0000_000B_3000_0000;
  localparam logic [63:0] A1C = 64'h0000_000B_4000_0000;

  logic clk = 0, rst_n = 0;
  logic [N_IN-1:0] irq = '0;
  logic reg_wr = 0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic msg_valid, msg_ready = 1;
  logic [63:0] msg_addr;
  logic [31:0] msg_data;
  int n_chk = 0, n_fail = 0, cyc = 0;
  logic [95:0] got [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  wire_msg_bridge #(.N_IN(N_IN)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .irq_i(irq),
    .reg_wr_i(reg_wr), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata),
    .reg_rdata_o(reg_rdata),
    .msg_valid_o(msg_valid), .msg_ready_i(msg_ready),
    .msg_addr_o(msg_addr), .msg_data_o(msg_data)
  );

  always @(negedge clk) if (rst_n && msg_valid && msg_ready) got.push_back({msg_addr, msg_data});
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string r, input logic [95:0] act, input logic [95:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    step(1);
    reg_wr = 0;
  endtask

  task automatic rd(input string r, input logic [11:0] a, input logic [31:0] e);
    reg_addr = a; #1;
    check(r, {64'd0, reg_rdata}, {64'd0, e});
  endtask

  task automatic exp_msg(input string r, input logic [63:0] a, input logic [31:0] d);
    if (got.size() == 0) check(r, 96'hx, {a, d});
    else check(r, got.pop_front(), {a, d});
  endtask

  task automatic exp_none(input string r);
    check(r, 96'(got.size()), 96'd0);
    got.delete();
  endtask

  function automatic logic [11:0] cfg_a(input int n);
    return 12'(32'h100 + 4 * n);
  endfunction

  task automatic t_reset;
    rd("R1", cfg_a(0), 0);
    rd("R1", 12'h010, 0);
    rd("R1", 12'h05C, 0);
    check("R1", {95'd0, msg_valid}, 96'd0);
  endtask

  task automatic t_regs;
    wr(12'h010, A0S[31:0]); wr(12'h014, A0S[63:32]);
    wr(12'h018, A0C[31:0]); wr(12'h01C, A0C[63:32]);
    wr(12'h050, A1S[31:0]); wr(12'h054, A1S[63:32]);
    wr(12'h058, A1C[31:0]); wr(12'h05C, A1C[63:32]);
    wr(cfg_a(5), 32'hDEAD_BEEF);
    rd("R2", 12'h014, A0S[63:32]);
    rd("R2", 12'h018, A0C[31:0]);
    rd("R2", 12'h050, A1S[31:0]);
    rd("R2", 12'h05C, A1C[63:32]);
    rd("R2", cfg_a(5), 32'hDEAD_BEEF);
    wr(cfg_a(5), 0);
  endtask

  task automatic t_level;
    wr(cfg_a(0), EN | 32'h55);
    irq[0] = 1; step(10);
    exp_msg("R4 raise", A0S, 32'h55);
    irq[0] = 0; step(10);
    exp_msg("R4 drop", A0C, 32'h55);
    exp_none("R4");
    // upper config bits must not leak into data
    wr(cfg_a(6), EN | 32'h00AB_CDEF);
    irq[6] = 1; step(10);
    exp_msg("R3 payload", A0S, 32'h00AB_CDEF);
    irq[6] = 0; step(10);
    exp_msg("R3 payload", A0C, 32'h00AB_CDEF);
  endtask

  task automatic t_edge;
    wr(cfg_a(1), EN | ED | 32'h66);
    irq[1] = 1; step(10);
    exp_msg("R5 edge", A0S, 32'h66);
    irq[1] = 0; step(10);
    exp_none("R5 edge fall");
    wr(cfg_a(2), EN | G1 | 32'h77);
    irq[2] = 1; step(10);
    exp_msg("R5 group1", A1S, 32'h77);
    irq[2] = 0; step(10);
    exp_none("R5 group1 fall");
    wr(cfg_a(7), EN | 32'h6000_0000 | 32'h11); // group 3: inactive
    irq[7] = 1; step(10); irq[7] = 0; step(10);
    exp_none("R3 bad group");
  endtask

  task automatic t_disable;
    wr(cfg_a(3), 32'h44);
    irq[3] = 1; step(10); irq[3] = 0; step(10);
    exp_none("R6 disabled");
    wr(cfg_a(0), 0);
    rd("R6", cfg_a(0), 0);
    irq[0] = 1; step(10); irq[0] = 0; step(10);
    exp_none("R6 zeroed");
  endtask

  task automatic t_cancel;
    logic [63:0] a1;
    wr(cfg_a(0), EN | 32'h55);
    msg_ready = 0;
    irq[1] = 1; step(10);
    a1 = msg_addr;
    irq[0] = 1; step(6); irq[0] = 0; step(10);
    check("R8 stable", {32'd0, msg_addr}, {32'd0, a1});
    check("R8 valid", {95'd0, msg_valid}, 96'd1);
    msg_ready = 1; step(10);
    exp_msg("R7", A0S, 32'h66);
    exp_none("R7 set cancelled");
    irq[1] = 0;
    irq[0] = 1; step(10);
    exp_msg("R7", A0S, 32'h55);
    msg_ready = 0;
    irq[2] = 1; step(10);
    irq[0] = 0; step(6); irq[0] = 1; step(10);
    msg_ready = 1; step(10);
    exp_msg("R7", A1S, 32'h77);
    exp_none("R7 drop cancelled");
    irq[0] = 0; irq[2] = 0; step(10);
    exp_msg("R7", A0C, 32'h55);
    exp_none("R7");
  endtask

  task automatic t_rr;
    wr(cfg_a(4), EN | 32'h44);
    irq[1] = 1; step(10); irq[1] = 0; step(10);
    exp_msg("R9 prime", A0S, 32'h66);
    msg_ready = 0;
    irq[0] = 1; irq[4] = 1; step(20);
    msg_ready = 1; step(10);
    exp_msg("R9 first", A0S, 32'h44);
    exp_msg("R9 second", A0S, 32'h55);
    irq[0] = 0; irq[4] = 0; step(10);
    exp_msg("R9 first", A0C, 32'h44);
    exp_msg("R9 second", A0C, 32'h55);
    exp_none("R9");
  endtask

  task automatic t_shared;
    wr(cfg_a(107), EN | 32'h107);
    wr(cfg_a(109), EN | 32'h107);
    irq[107] = 1; irq[109] = 1; step(10);
    exp_msg("R10 both", A0S, 32'h107);
    exp_none("R10 no dup");
    irq[107] = 0; irq[109] = 0; step(10);
    exp_msg("R10 both", A0C, 32'h107);
    exp_none("R10 no dup");
    irq[109] = 1; step(10);
    exp_msg("R10 single", A0S, 32'h107);
    irq[109] = 0; step(10);
    exp_msg("R10 single", A0C, 32'h107);
    exp_none("R10");
  endtask

  initial begin
    forever begin
      @(posedge clk);
      if (cyc > 50000) begin
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=%0d expected<=50000", cyc);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
      end
    end
  end

  initial begin
    step(3);
    t_reset;
    rst_n = 1;
    step(2);
    t_reset;
    t_regs;
    t_level;
    t_edge;
    t_disable;
    t_cancel;
    t_rr;
    t_shared;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule